// File: doc/BRIEF.md
# Byte ALU with Status Flags

An 8-bit arithmetic and logic unit paired with the status flag register it updates. Each cycle the unit takes an operation code and two operands, `a_i` and `b_i`. It reads the stored carry and auxiliary-carry flags and drives the result and a skip indication without a register in between. When `valid_i` is high, the flags that the operation owns are written into the status register at the next clock edge.

Arithmetic uses a single adder. For subtraction the adder gets the inverted second operand, so the carry and auxiliary-carry flags carry no-borrow meaning. The status register also holds a power-down flag and a timeout flag. Only halt, clear-watchdog and timeout events can move these two flags, and a software write of the status byte never changes them. The watchdog timer and the instruction sequencer are outside this block. They drive the event inputs and the operation strobe.

Top module: `alu8_flags`

## Requirements
- R1: `status_o` holds C in bit 0, AC in bit 1, Z in bit 2, OV in bit 3, PD in bit 4 and TO in bit 5. Bits 7 and 6 always read 0. The whole byte is 00h after reset.
- R2: Opcode 0 (add) gives `a+b` and opcode 1 (add with carry) gives `a+b+C`, each modulo 256. C is set to the carry out of bit 7.
- R3: Opcode 2 (subtract) gives `a-b` and opcode 3 (subtract with borrow) gives `a-b-(1-C)`, each modulo 256. C is set exactly when no borrow occurs.
- R4: For opcodes 0 to 3, AC is set when the low nibble carries out on addition, or does not borrow on subtraction.
- R5: For opcodes 0 to 3, OV is set when the carry into bit 7 differs from the carry out of bit 7, which is the same as signed overflow.
- R6: Z is set when the result is zero and cleared otherwise. This applies to opcodes 0 to 8 (arithmetic, decimal adjust, AND=5, OR=6, XOR=7, complement=8) and to increment=13 and decrement=14.
- R7: Opcodes 5 to 8, 13 and 14 leave C, AC and OV unchanged. Opcode 9 (rotate left) and opcode 10 (rotate right) change no flag.
- R8: Opcode 11 gives `{a[6:0],C}` and loads C from a[7]. Opcode 12 gives `{C,a[7:1]}` and loads C from a[0].
- R9: Opcode 4 (decimal adjust) adds 06h to `a` when a[3:0] > 9 or AC=1. It adds 60h when `a` > 99h or C=1, and in that case sets C. Otherwise C is kept. AC and OV are kept.
- R10: `skip_o` is high when opcode 13 or 14 gives a zero result, when opcode 15 sees a=0, or when opcode 16 sees a≠0. It is low for every other opcode, including opcodes 17 to 31, which also pass `a` through and change no flag.
- R11: `wr_stat_i` loads status bits 3..0 from `wr_data_i[3:0]` and leaves PD and TO untouched. In a cycle where both `wr_stat_i` and `valid_i` are high, the write wins.
- R12: PD is set by `halt_i` and cleared by `clr_wdt_i`. If both are high, halt wins.
- R13: TO is set by `wdt_to_i` and cleared by `halt_i` or `clr_wdt_i`. If a timeout and a clear arrive in the same cycle, the timeout wins.
- R14: With `valid_i` low and no write, C, AC, Z and OV keep their values whatever the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Commit the flags of the current operation |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| wr_stat_i | input | 1 | Software write of the status byte |
| wr_data_i | input | 8 | Status write data |
| clr_wdt_i | input | 1 | Clear-watchdog event |
| halt_i | input | 1 | Halt event |
| wdt_to_i | input | 1 | Watchdog timeout event |
| res_o | output | 8 | Operation result (combinational) |
| skip_o | output | 1 | Skip condition (combinational) |
| status_o | output | 8 | Status register |

## Verification
The bench builds the block with its default width of 8, the only width at which decimal adjust and the status byte are meaningful. At this width every operand pair can be reached. Directed cases hit the nibble and bit-7 carry boundaries: 80h+80h, 80h−01h, 0Fh plus carry, and a decimal adjust of 9Ah that wraps to zero. A run of random opcodes and operands then chains the carry from one operation into the next. The event inputs are driven alone and in pairs to exercise the priority rules of R12 and R13.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_DAA  = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_CPL  = 5'd8,
    OP_RL   = 5'd9,
    OP_RR   = 5'd10,
    OP_RLC  = 5'd11,
    OP_RRC  = 5'd12,
    OP_INC  = 5'd13,
    OP_DEC  = 5'd14,
    OP_SZ   = 5'd15,
    OP_SNZ  = 5'd16
  } alu_op_e;

  localparam int unsigned STAT_W  = 8;
  localparam int unsigned BIT_C   = 0;
  localparam int unsigned BIT_AC  = 1;
  localparam int unsigned BIT_Z   = 2;
  localparam int unsigned BIT_OV  = 3;
  localparam int unsigned BIT_PD  = 4;
  localparam int unsigned BIT_TO  = 5;

  // per-flag write enables plus new values
  typedef struct packed {
    logic en_c;
    logic en_ac;
    logic en_z;
    logic en_ov;
    logic c;
    logic ac;
    logic z;
    logic ov;
  } flag_upd_t;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_out_o,
  output logic         c_half_o,
  output logic         ov_o
);
  localparam int unsigned NIB = W / 2;

  logic [W:0] full;
  logic       c_msb_in;

  assign full     = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
  assign sum_o    = full[W-1:0];
  assign c_out_o  = full[W];
  assign c_half_o = x_i[NIB] ^ y_i[NIB] ^ full[NIB];
  assign c_msb_in = x_i[W-1] ^ y_i[W-1] ^ full[W-1];
  assign ov_o     = c_msb_in ^ full[W];

endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  input  logic         ac_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         ac_o,
  output logic         ov_o,
  output logic         daa_c_o
);
  localparam int unsigned NIB     = W / 2;
  localparam logic [W-1:0] FIX_LO  = W'(6);
  localparam logic [W-1:0] FIX_HI  = W'(6) << NIB;
  localparam logic [W-1:0] BCD_MAX = W'((9 << NIB) | 9);
  localparam logic [NIB-1:0] DIG_MAX = NIB'(9);

  logic [W-1:0] y;
  logic         cin;
  logic         lo_fix, hi_fix;

  assign lo_fix  = (a_i[NIB-1:0] > DIG_MAX) | ac_i;
  assign hi_fix  = (a_i > BCD_MAX) | c_i;
  assign daa_c_o = c_i | hi_fix;

  // one adder serves every arithmetic opcode
  always_comb begin
    y   = b_i;
    cin = 1'b0;
    unique case (op_i)
      OP_ADC:  cin = c_i;
      OP_SUB:  begin y = ~b_i; cin = 1'b1; end
      OP_SBC:  begin y = ~b_i; cin = c_i;  end
      OP_INC:  begin y = '0;   cin = 1'b1; end
      OP_DEC:  y = '1;
      OP_DAA:  y = (FIX_LO & {W{lo_fix}}) | (FIX_HI & {W{hi_fix}});
      default: ;
    endcase
  end

  alu_adder #(.W(W)) u_add (
    .x_i     (a_i),
    .y_i     (y),
    .cin_i   (cin),
    .sum_o   (res_o),
    .c_out_o (c_o),
    .c_half_o(ac_o),
    .ov_o    (ov_o)
  );

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  always_comb begin
    res_o = a_i;
    c_o   = c_i;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_CPL: res_o = ~a_i;
      OP_RL:  res_o = {a_i[W-2:0], a_i[W-1]};
      OP_RR:  res_o = {a_i[0], a_i[W-1:1]};
      OP_RLC: begin res_o = {a_i[W-2:0], c_i}; c_o = a_i[W-1]; end
      OP_RRC: begin res_o = {c_i, a_i[W-1:1]}; c_o = a_i[0];   end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_stat_reg.sv
module alu_stat_reg
  import alu8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  flag_upd_t         upd_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic              clr_wdt_i,
  input  logic              halt_i,
  input  logic              wdt_to_i,
  output logic [STAT_W-1:0] status_o
);
  logic c_q, ac_q, z_q, ov_q, pd_q, to_q;
  logic unused_wr;

  assign unused_wr = ^wr_data_i[STAT_W-1:BIT_PD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q  <= 1'b0;
      ac_q <= 1'b0;
      z_q  <= 1'b0;
      ov_q <= 1'b0;
      pd_q <= 1'b0;
      to_q <= 1'b0;
    end else begin
      if (upd_en_i) begin
        if (upd_i.en_c)  c_q  <= upd_i.c;
        if (upd_i.en_ac) ac_q <= upd_i.ac;
        if (upd_i.en_z)  z_q  <= upd_i.z;
        if (upd_i.en_ov) ov_q <= upd_i.ov;
      end
      // software write placed last: it wins
      if (wr_en_i) begin
        c_q  <= wr_data_i[BIT_C];
        ac_q <= wr_data_i[BIT_AC];
        z_q  <= wr_data_i[BIT_Z];
        ov_q <= wr_data_i[BIT_OV];
      end
      if (halt_i)         pd_q <= 1'b1;
      else if (clr_wdt_i) pd_q <= 1'b0;
      if (wdt_to_i)                to_q <= 1'b1;
      else if (halt_i || clr_wdt_i) to_q <= 1'b0;
    end
  end

  assign status_o = {2'b00, to_q, pd_q, ov_q, z_q, ac_q, c_q};

  AST_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:6] == 2'b00); // R1
  AST_PD_SOFT_IMMUNE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_i && !clr_wdt_i) |=> $stable(status_o[BIT_PD])); // R11
  AST_HALT_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !wdt_to_i) |=> (status_o[BIT_PD] && !status_o[BIT_TO])); // R12
  AST_TO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_to_i |=> status_o[BIT_TO]); // R13

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [4:0]        op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic              wr_stat_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic              clr_wdt_i,
  input  logic              halt_i,
  input  logic              wdt_to_i,
  output logic [W-1:0]      res_o,
  output logic              skip_o,
  output logic [STAT_W-1:0] status_o
);
  alu_op_e   op;
  logic [W-1:0] ar_res, lg_res;
  logic      ar_c, ar_ac, ar_ov, daa_c, lg_c;
  logic      is_arith, res_zero;
  flag_upd_t upd;

  assign op = alu_op_e'(op_i);

  alu_arith #(.W(W)) u_arith (
    .op_i   (op),
    .a_i    (a_i),
    .b_i    (b_i),
    .c_i    (status_o[BIT_C]),
    .ac_i   (status_o[BIT_AC]),
    .res_o  (ar_res),
    .c_o    (ar_c),
    .ac_o   (ar_ac),
    .ov_o   (ar_ov),
    .daa_c_o(daa_c)
  );

  alu_logic #(.W(W)) u_logic (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_i),
    .c_i  (status_o[BIT_C]),
    .res_o(lg_res),
    .c_o  (lg_c)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_DAA, OP_INC, OP_DEC: is_arith = 1'b1;
      default: is_arith = 1'b0;
    endcase
  end

  assign res_o    = is_arith ? ar_res : lg_res;
  assign res_zero = (res_o == '0);

  always_comb begin
    unique case (op)
      OP_INC, OP_DEC: skip_o = res_zero;
      OP_SZ:          skip_o = (a_i == '0);
      OP_SNZ:         skip_o = (a_i != '0);
      default:        skip_o = 1'b0;
    endcase
  end

  always_comb begin
    upd    = '0;
    upd.c  = ar_c;
    upd.ac = ar_ac;
    upd.ov = ar_ov;
    upd.z  = res_zero;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        upd.en_c = 1'b1; upd.en_ac = 1'b1; upd.en_ov = 1'b1; upd.en_z = 1'b1;
      end
      OP_DAA: begin
        upd.en_c = 1'b1; upd.c = daa_c; upd.en_z = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_CPL, OP_INC, OP_DEC: upd.en_z = 1'b1;
      OP_RLC, OP_RRC: begin
        upd.en_c = 1'b1; upd.c = lg_c;
      end
      default: ;
    endcase
  end

  alu_stat_reg u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_en_i (valid_i),
    .upd_i    (upd),
    .wr_en_i  (wr_stat_i),
    .wr_data_i(wr_data_i),
    .clr_wdt_i(clr_wdt_i),
    .halt_i   (halt_i),
    .wdt_to_i (wdt_to_i),
    .status_o (status_o)
  );

  AST_NOVALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !wr_stat_i) |=> $stable(status_o[3:0])); // R14
  AST_LOGIC_KEEP_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !wr_stat_i && (op_i inside {5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd13, 5'd14}))
      |=> $stable(status_o[1:0])); // R7
  AST_SKIP_OPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> (op_i inside {5'd13, 5'd14, 5'd15, 5'd16})); // R10

endmodule

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, wr = 1'b0, clr = 1'b0, hlt = 1'b0, wto = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0, wd = '0;
  logic [7:0] res, status;
  logic       skip;
  int         checks = 0, errors = 0;
  logic [7:0] m_st = '0;

  typedef struct {
    logic [7:0] res;
    logic       skip;
    logic [7:0] st;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  alu8_flags u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
    .wr_stat_i(wr), .wr_data_i(wd), .clr_wdt_i(clr), .halt_i(hlt), .wdt_to_i(wto),
    .res_o(res), .skip_o(skip), .status_o(status)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: computes expected values from the requirements and queues them
  task automatic step(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                      input logic v, input logic w, input logic [7:0] wdat,
                      input logic cw, input logic h, input logic t, input string tag);
    exp_t e;
    int   ci, aci, bw, s, sl, sv;
    logic [7:0] r;
    logic sk;
    logic [7:0] ns;
    @(negedge clk);
    op = o; a = x; b = y; valid = v; wr = w; wd = wdat; clr = cw; hlt = h; wto = t;
    ci = int'(m_st[0]); aci = int'(m_st[1]);
    ns = m_st; r = x; sk = 1'b0;
    case (o)
      5'd0, 5'd1: begin
        bw = (o == 5'd1) ? ci : 0;
        s  = int'(x) + int'(y) + bw;
        sl = int'(x[3:0]) + int'(y[3:0]) + bw;
        sv = int'($signed(x)) + int'($signed(y)) + bw;
        r  = s[7:0];
        if (v) begin
          ns[0] = (s > 255); ns[1] = (sl > 15);
          ns[3] = (sv > 127) || (sv < -128); ns[2] = (r == 0);
        end
      end
      5'd2, 5'd3: begin
        bw = (o == 5'd3) ? 1 - ci : 0;
        s  = int'(x) - int'(y) - bw;
        sl = int'(x[3:0]) - int'(y[3:0]) - bw;
        sv = int'($signed(x)) - int'($signed(y)) - bw;
        r  = s[7:0];
        if (v) begin
          ns[0] = (s >= 0); ns[1] = (sl >= 0);
          ns[3] = (sv > 127) || (sv < -128); ns[2] = (r == 0);
        end
      end
      5'd4: begin
        s = int'(x);
        if (x[3:0] > 4'd9 || aci == 1) s = s + 6;
        if (x > 8'h99 || ci == 1) begin s = s + 96; if (v) ns[0] = 1'b1; end
        r = s[7:0];
        if (v) ns[2] = (r == 0);
      end
      5'd5:  begin r = x & y; if (v) ns[2] = (r == 0); end
      5'd6:  begin r = x | y; if (v) ns[2] = (r == 0); end
      5'd7:  begin r = x ^ y; if (v) ns[2] = (r == 0); end
      5'd8:  begin r = ~x;    if (v) ns[2] = (r == 0); end
      5'd9:  r = {x[6:0], x[7]};
      5'd10: r = {x[0], x[7:1]};
      5'd11: begin r = {x[6:0], m_st[0]}; if (v) ns[0] = x[7]; end
      5'd12: begin r = {m_st[0], x[7:1]}; if (v) ns[0] = x[0]; end
      5'd13: begin r = x + 8'd1; sk = (r == 0); if (v) ns[2] = (r == 0); end
      5'd14: begin r = x - 8'd1; sk = (r == 0); if (v) ns[2] = (r == 0); end
      5'd15: sk = (x == 0);
      5'd16: sk = (x != 0);
      default: ;
    endcase
    if (w) ns[3:0] = wdat[3:0];
    if (h) ns[4] = 1'b1; else if (cw) ns[4] = 1'b0;
    if (t) ns[5] = 1'b1; else if (h || cw) ns[5] = 1'b0;
    m_st = ns;
    e.res = r; e.skip = sk; e.st = ns; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic alu(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y, input string tag);
    step(o, x, y, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic evt(input logic w, input logic [7:0] wdat, input logic cw, input logic h,
                     input logic t, input string tag);
    step(5'd31, 8'h00, 8'h00, 1'b0, w, wdat, cw, h, t, tag);
  endtask

  // monitor: pops expected items and compares as the design produces them
  initial begin
    exp_t cur;
    forever begin
      wait (q.size() > 0);
      #1;
      cur = q[0];
      chk({cur.tag, " res"}, res, cur.res);
      chk({cur.tag, " skip"}, {7'd0, skip}, {7'd0, cur.skip});
      @(posedge clk);
      #1;
      chk({cur.tag, " status"}, status, cur.st);
      void'(q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset status", status, 8'h00);

    alu(5'd0, 8'h3A, 8'h28, "R2 R4 add half carry");
    alu(5'd0, 8'h80, 8'h80, "R2 R5 R6 add wrap");
    alu(5'd1, 8'h0F, 8'h00, "R2 R4 adc with carry");
    alu(5'd2, 8'h50, 8'h20, "R3 sub no borrow");
    alu(5'd2, 8'h20, 8'h50, "R3 R4 sub borrow");
    alu(5'd3, 8'h10, 8'h01, "R3 sbc borrow in");
    alu(5'd2, 8'h80, 8'h01, "R5 sub overflow");
    alu(5'd2, 8'h33, 8'h33, "R6 sub zero");
    alu(5'd0, 8'h19, 8'h28, "R9 add before adjust");
    alu(5'd4, 8'h41, 8'h00, "R9 adjust low");
    alu(5'd0, 8'h00, 8'h00, "R6 clear carry");
    alu(5'd4, 8'h9A, 8'h00, "R9 adjust wrap");
    evt(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, "R11 write all ones");
    alu(5'd5, 8'hF0, 8'h0F, "R6 R7 and zero");
    alu(5'd6, 8'h50, 8'h0A, "R7 or");
    alu(5'd7, 8'hAA, 8'hAA, "R7 xor zero");
    alu(5'd8, 8'h5A, 8'h00, "R7 complement");
    alu(5'd9, 8'h81, 8'h00, "R7 rotate left");
    alu(5'd10, 8'h81, 8'h00, "R7 rotate right");
    alu(5'd11, 8'h80, 8'h00, "R8 rlc");
    alu(5'd12, 8'h02, 8'h00, "R8 rrc");
    alu(5'd12, 8'h01, 8'h00, "R8 rrc carry out");
    alu(5'd13, 8'hFF, 8'h00, "R10 inc wrap skip");
    alu(5'd13, 8'h05, 8'h00, "R10 inc no skip");
    alu(5'd14, 8'h01, 8'h00, "R10 dec skip");
    alu(5'd15, 8'h00, 8'h00, "R10 zero test");
    alu(5'd15, 8'h03, 8'h00, "R10 zero test miss");
    alu(5'd16, 8'h00, 8'h00, "R10 nonzero test miss");
    alu(5'd16, 8'h40, 8'h00, "R10 nonzero test");
    alu(5'd20, 8'h00, 8'h77, "R10 unused opcode");
    step(5'd0, 8'h80, 8'h80, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R14 no valid");
    step(5'd0, 8'hFF, 8'h01, 1'b1, 1'b1, 8'h06, 1'b0, 1'b0, 1'b0, "R11 write wins");
    evt(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R12 halt");
    evt(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R11 R12 write keeps pd");
    evt(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R13 timeout");
    evt(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R11 R13 write keeps to");
    evt(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R12 R13 clear watchdog");
    evt(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, "R13 timeout beats clear");
    evt(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, "R12 halt beats clear");
    evt(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R13 halt clears to");

    for (int i = 0; i < 300; i++) begin
      step(5'($urandom_range(0, 17)), 8'($urandom), 8'($urandom), 1'($urandom_range(0, 3) != 0),
           1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R2 R3 R4 R5 R6 R9 random");
    end

    @(negedge clk);
    valid = 1'b0; wr = 1'b0; clr = 1'b0; hlt = 1'b0; wto = 1'b0;
    wait (q.size() == 0);
    #1;
    finish_run();
  end
endmodule